// File: doc/BRIEF.md
# Decimal Matrix Code Encoder

This block computes the check bits that protect a 32-bit memory word against upsets that strike several neighbouring cells at once. The word is viewed, in logic only, as eight 4-bit symbols laid out in two rows of four. Inside each row, a symbol is added to the symbol two columns to its right as an unsigned integer. Each sum keeps its carry, so it is five bits wide and is used as a horizontal check group. Across the two rows, matching bit positions are combined with XOR to form the vertical check bits. The physical arrangement of the memory cells is not changed.

The data bits, the 20 horizontal bits and the 16 vertical bits are packed into a 68-bit codeword that goes to the array on a write. An enable input qualifies the check logic. While it is low, the check outputs are forced to zero, so the adders and XOR trees can be lent to a decoder that recomputes checks on a read. One output register stage is present by default for timing.

Top module: `dmc_encoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, horizChk, vertChk and codeWord are all zero.
- R2: With the enable high, horizChk[4:0] equals the 5-bit unsigned sum of dataIn[3:0] and dataIn[11:8].
- R3: With the enable high, horizChk[9:5] equals the 5-bit unsigned sum of dataIn[7:4] and dataIn[15:12].
- R4: With the enable high, horizChk[14:10] equals dataIn[19:16] + dataIn[27:24], and horizChk[19:15] equals dataIn[23:20] + dataIn[31:28], each as a 5-bit unsigned sum.
- R5: Every sum keeps its carry as the fifth bit, so no overflow occurs: 4'b1100 + 4'b0110 gives 5'b10010, and 4'b1111 + 4'b1111 gives 5'b11110.
- R6: With the enable high, vertChk[i] equals dataIn[i] XOR dataIn[i+16] for every i from 0 to 15.
- R7: codeWord[31:0] is dataIn unchanged, codeWord[51:32] is horizChk and codeWord[67:52] is vertChk.
- R8: With the enable low, horizChk, vertChk and codeWord[67:32] are zero, and codeWord[31:0] still carries dataIn.
- R9: Every output reflects the inputs that were present at the previous rising clock edge, which is one cycle of latency.
- R10: Two words that differ only by flips of dataIn[i] and dataIn[i+16] produce the same vertChk but a different horizChk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| encEn | input | 1 | Enable that qualifies the check outputs |
| dataIn | input | 32 | Information word to encode |
| horizChk | output | 20 | Four 5-bit symbol-pair sums |
| vertChk | output | 16 | Column XOR bits |
| codeWord | output | 68 | {vertChk, horizChk, dataIn} |

## Verification
The case that is hardest to reach from the ports is a carry out of a symbol sum. It needs both nibbles of a pair to be large, and random words seldom put the extreme values 15+15 and 8+8 on every pair together. The bench therefore runs through all 256 pairs of nibble values and places each pair, rotated, on all four groups. It then applies flips to bit positions i and i+16 of the same word, which cancel in the column XOR, and confirms that only the sums detect them.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int SYM_W  = 4;
  localparam int ROWS   = 2;
  localparam int COLS   = 4;
  localparam int HALF   = COLS / 2;
  localparam int ROW_W  = COLS * SYM_W;
  localparam int DATA_W = ROWS * ROW_W;
  localparam int SUM_W  = SYM_W + 1;
  localparam int GRPS   = ROWS * HALF;
  localparam int H_W    = GRPS * SUM_W;
  localparam int V_W    = ROW_W;
  localparam int CW_W   = DATA_W + H_W + V_W;

  typedef struct packed {
    logic chkEn;
    logic loadEn;
  } encStrobe_t;
endpackage

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
(
  input  logic       encEn,
  output encStrobe_t strb
);
  always_comb begin
    strb.chkEn  = encEn;
    strb.loadEn = 1'b1;
  end
endmodule

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  encStrobe_t        strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [H_W-1:0]    horizChk,
  output logic [V_W-1:0]    vertChk,
  output logic [CW_W-1:0]   codeWord
);
  logic [H_W-1:0]  hRaw;
  logic [V_W-1:0]  vRaw;
  logic [H_W-1:0]  hGated;
  logic [V_W-1:0]  vGated;
  logic [CW_W-1:0] cwNext;

  // symbol-pair adders: symbol c plus symbol c+HALF inside each row
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < HALF; c++) begin : gPair
      localparam int LoBase = (r * COLS + c) * SYM_W;
      localparam int HiBase = (r * COLS + c + HALF) * SYM_W;
      localparam int Grp    = r * HALF + c;
      assign hRaw[Grp*SUM_W +: SUM_W] =
        {1'b0, dataIn[LoBase +: SYM_W]} + {1'b0, dataIn[HiBase +: SYM_W]};
    end
  end

  // column XOR across rows
  always_comb begin
    vRaw = '0;
    for (int r = 0; r < ROWS; r++) begin
      vRaw = vRaw ^ dataIn[r*ROW_W +: ROW_W];
    end
  end

  assign hGated = strb.chkEn ? hRaw : '0;
  assign vGated = strb.chkEn ? vRaw : '0;
  assign cwNext = {vGated, hGated, dataIn};

  if (OUT_REG) begin : gReg
    logic [CW_W-1:0] cwQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cwQ <= '0;
      end else if (strb.loadEn) begin
        cwQ <= cwNext;
      end
    end
    assign codeWord = cwQ;
  end else begin : gComb
    assign codeWord = cwNext;
  end

  assign horizChk = codeWord[DATA_W +: H_W];
  assign vertChk  = codeWord[DATA_W+H_W +: V_W];
endmodule

// File: rtl/dmc_encoder.sv
module dmc_encoder
  import dmc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              encEn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [H_W-1:0]    horizChk,
  output logic [V_W-1:0]    vertChk,
  output logic [CW_W-1:0]   codeWord
);
  encStrobe_t strb;

  dmc_control u_ctrl (
    .encEn (encEn),
    .strb  (strb)
  );

  dmc_datapath #(.OUT_REG(OUT_REG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .horizChk (horizChk),
    .vertChk  (vertChk),
    .codeWord (codeWord)
  );
endmodule

// File: rtl/dmc_enc_chk.sv
module dmc_enc_chk
  import dmc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              encEn,
  input logic [DATA_W-1:0] dataIn,
  input logic [H_W-1:0]    horizChk,
  input logic [V_W-1:0]    vertChk,
  input logic [CW_W-1:0]   codeWord
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |-> (codeWord == '0));

  // R2
  low_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(encEn)) |->
      (horizChk[4:0] == ({1'b0, $past(dataIn[3:0])} + {1'b0, $past(dataIn[11:8])})));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(encEn) && horizChk[4]) |->
      (({1'b0, $past(dataIn[3:0])} + {1'b0, $past(dataIn[11:8])}) >= 5'd16));

  // R6
  column_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(encEn)) |->
      (vertChk == ($past(dataIn[15:0]) ^ $past(dataIn[31:16]))));

  // R7
  layout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeWord[51:32] == horizChk) && (codeWord[67:52] == vertChk));

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(encEn)) |-> (horizChk == '0 && vertChk == '0));

  // R9
  data_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (codeWord[31:0] == $past(dataIn)));
endmodule

bind dmc_encoder dmc_enc_chk u_chk (.*);

// File: tb/tb_dmc_encoder.sv
module tb_dmc_encoder;
  localparam int ClkPeriod = 10;
  localparam int WatchdogCycles = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encEn = 1'b0;
  logic [31:0] dataIn = '0;
  logic [19:0] horizChk;
  logic [15:0] vertChk;
  logic [67:0] codeWord;

  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;

  dmc_encoder dut (
    .clk(clk), .rstN(rstN), .encEn(encEn), .dataIn(dataIn),
    .horizChk(horizChk), .vertChk(vertChk), .codeWord(codeWord)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] nsum(input logic [3:0] a, input logic [3:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Drive at a falling edge, sample at the next falling edge (one register: R9).
  task automatic apply(input logic [31:0] d, input logic en);
    logic [19:0] eh;
    logic [15:0] ev;
    @(negedge clk);
    dataIn = d;
    encEn  = en;
    @(negedge clk);
    eh = {nsum(d[23:20], d[31:28]), nsum(d[19:16], d[27:24]),
          nsum(d[7:4], d[15:12]), nsum(d[3:0], d[11:8])};
    ev = d[15:0] ^ d[31:16];
    if (en) begin
      check("R2", 68'(horizChk[4:0]), 68'(eh[4:0]));
      check("R3", 68'(horizChk[9:5]), 68'(eh[9:5]));
      check("R4", 68'(horizChk[19:10]), 68'(eh[19:10]));
      check("R6", 68'(vertChk), 68'(ev));
      check("R7", codeWord, {ev, eh, d});
    end else begin
      check("R8", codeWord, {36'h0, d});
    end
  endtask

  initial begin
    int cyc = 0;
    while (!doneFlag) begin
      @(posedge clk);
      cyc++;
      if (cyc > WatchdogCycles && !doneFlag) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WatchdogCycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [19:0] hA;
    logic [15:0] vA;
    dataIn = 32'hFFFF_FFFF;
    encEn  = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero under reset
    check("R1", codeWord, 68'h0);
    rstN = 1'b1;
    // R1: first cycle after release still shows the reset value
    #1 check("R1", codeWord, 68'h0);

    // R5: carry examples
    apply({16'h0, 4'h0, 4'h6, 4'h0, 4'hC}, 1'b1);
    check("R5", 68'(horizChk[4:0]), 68'(5'b10010));
    apply({4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0, 4'hF, 4'h0}, 1'b1);
    check("R5", 68'(horizChk[19:15]), 68'(5'b11110));

    // exhaustive nibble pairs on every group (R2, R3, R4, R5)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] x, y;
        x = 4'(a);
        y = 4'(b);
        apply({~y, y, x, ~x, y, ~y, ~x, x}, 1'b1);
      end
    end

    // pseudo-random words with the enable toggling (R6, R7, R8, R9)
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr, (i % 5) != 3);
    end

    // R8: disabled with all ones
    apply(32'hFFFF_FFFF, 1'b0);

    // R10: paired flips in a column position
    for (int i = 0; i < 16; i++) begin
      logic [31:0] base;
      base = 32'h3C5A_96E1;
      apply(base, 1'b1);
      hA = horizChk;
      vA = vertChk;
      base[i] = ~base[i];
      base[i+16] = ~base[i+16];
      apply(base, 1'b1);
      check("R10", 68'(vertChk), 68'(vA));
      total++;
      if (horizChk === hA) begin
        bad++;
        $display("FAIL R10 actual=%h expected!=%h", horizChk, hA);
      end
    end

    doneFlag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule